// File: doc/BRIEF.md
# Seconds Counter with Byte-Wide Register Access and Alarm

This block keeps a 32-bit count of elapsed seconds. An external one-second strobe advances the count while the run control bit is set. The block generates no timebase of its own and does no calendar conversion.

A host reaches the block through a plain 8-bit register port with an address, a write strobe and write data. Read data is combinational from the address. A new time is loaded in byte-sized pieces. The three upper bytes go into holding registers. Writing the lowest byte then loads the whole 32-bit value into the counter in one step. The intended order is: write zero to the lowest byte, write the upper bytes, then write the true lowest byte.

A 32-bit alarm value is compared with the live count while the alarm enable bit is set. A match latches a pending flag, which drives the interrupt line as a level. The flag stays set until the host writes the clear bit.

Top module: `sec_alarm_counter`

## Requirements
- R1: After a synchronous active-low reset, the count, the alarm value, the run bit and the alarm enable bit are zero, the interrupt is low, and every address reads 0x00.
- R2: The address map is 0x00 control, 0x01 alarm control, 0x02..0x05 time write window, 0x06..0x09 live count, 0x0A..0x0D alarm value, 0x0E alarm clear. Multi-byte fields place their least significant byte at the lowest address. Address 0x0F reads 0x00, and writes to it change nothing.
- R3: Bit 7 of the control register is the run bit, and it reads back. The other control bits read 0. A tick pulse adds one to the count only while the run bit is 1.
- R4: A tick at count 0xFFFFFFFF wraps the count to 0x00000000.
- R5: Writes to 0x03..0x05 are held and do not change the count. A write to 0x02 loads the count with {byte at 0x05, byte at 0x04, byte at 0x03, written data}. The write window reads 0x00.
- R6: A write to 0x02 in the same cycle as a tick loads the written value, and that tick adds nothing.
- R7: The four alarm value bytes read back exactly as they were written.
- R8: Bit 7 of the alarm control register is the alarm enable, and it reads back. While it is 1 and the count equals the alarm value, the interrupt goes high on the next clock edge. While it is 0, no match raises the interrupt.
- R9: The interrupt stays high until a write to 0x0E with bit 0 set. That write lowers it at the next edge. Writing 0x0E with bit 0 clear has no effect, and 0x0E always reads 0x00.
- R10: The live count window reflects every tick at once. After a tick that carries out of the lowest byte, byte 0x06 reads lower than it did before the tick and byte 0x07 has gone up by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | One-cycle seconds strobe |
| reg_addr_i | input | 4 | Register address |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational) |
| alarm_irq_o | output | 1 | Alarm interrupt, level |

## Verification
The assertions check the cycle-level rules on every cycle:
- the count holds while stopped;
- the count steps by exactly one on a running tick;
- a commit loads the held bytes together with the written data;
- the interrupt can only rise after an enabled match, holds until cleared, and drops after a clear.

The bench scenarios cover what a single cycle cannot show:
- the full byte-ordered load sequence;
- carries across byte boundaries and the wrap at the top of the range;
- the priority of a commit over a tick arriving in the same cycle;
- alarm matches at a sweep of distances from the loaded time, with the exact tick on which the interrupt appears.

// File: rtl/sac_pkg.sv
// Shared constants for the seconds/alarm counter: fixed register offsets
// and bit positions. Offsets that depend on the byte count are derived
// in the modules from their NB parameter.
package sac_pkg;
    localparam int SAC_NBYTES   = 4;
    localparam int SAC_DW       = 8;
    localparam int SAC_AW       = 4;
    localparam int OFF_CTRL     = 0;
    localparam int OFF_ACTL     = 1;
    localparam int OFF_WWIN     = 2;
    localparam int RUN_BIT      = 7;
    localparam int AEN_BIT      = 7;
    localparam int ACLR_BIT     = 0;

    typedef struct packed {
        logic ctrl;
        logic actl;
        logic aclr;
    } sac_wstb_t;
endpackage

// File: rtl/sac_regdec.sv
// Address decoder and read multiplexer. Turns the host write strobe into
// one strobe per register and selects read data combinationally.
// Assumes ADDR_W wide enough for OFF_WWIN + 3*NB addresses.
module sac_regdec
    import sac_pkg::*;
#(
    parameter int NB     = SAC_NBYTES,
    parameter int DW     = SAC_DW,
    parameter int ADDR_W = SAC_AW
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              we_i,
    input  logic              run_i,
    input  logic              aen_i,
    input  logic [NB*DW-1:0]  count_i,
    input  logic [NB*DW-1:0]  aval_i,
    output sac_wstb_t         wstb_o,
    output logic [NB-1:0]     wwin_we_o,
    output logic [NB-1:0]     aval_we_o,
    output logic [DW-1:0]     rdata_o
);
    localparam int OFF_RWIN  = OFF_WWIN + NB;
    localparam int OFF_AVAL  = OFF_RWIN + NB;
    localparam int OFF_ACTL2 = OFF_AVAL + NB;

    logic [31:0] addr_w;
    assign addr_w = 32'(addr_i);

    // Single-register write strobes.
    assign wstb_o.ctrl = we_i && (addr_w == 32'(OFF_CTRL));
    assign wstb_o.actl = we_i && (addr_w == 32'(OFF_ACTL));
    assign wstb_o.aclr = we_i && (addr_w == 32'(OFF_ACTL2));

    // Per-byte write strobes for the write window and the alarm value.
    for (genvar i = 0; i < NB; i++) begin : g_bstb
        assign wwin_we_o[i] = we_i && (addr_w == 32'(OFF_WWIN + i));
        assign aval_we_o[i] = we_i && (addr_w == 32'(OFF_AVAL + i));
    end

    // Read multiplexer; unmapped and write-only addresses return zero.
    always_comb begin
        rdata_o = '0;
        if (addr_w == 32'(OFF_CTRL)) rdata_o[RUN_BIT] = run_i;
        if (addr_w == 32'(OFF_ACTL)) rdata_o[AEN_BIT] = aen_i;
        for (int i = 0; i < NB; i++) begin
            if (addr_w == 32'(OFF_RWIN + i)) rdata_o = count_i[i*DW +: DW];
            if (addr_w == 32'(OFF_AVAL + i)) rdata_o = aval_i[i*DW +: DW];
        end
    end

    // R2: at most one byte strobe is active for any write.
    always_comb begin
        a_r2_onehot: assert ($onehot0({wwin_we_o, aval_we_o, wstb_o.ctrl, wstb_o.actl, wstb_o.aclr}));
    end
endmodule

// File: rtl/sac_counter.sv
// Seconds counter with run control and byte-wise time loading.
// Upper bytes are held until the lowest byte is written, which commits
// the whole value. A commit wins over a tick in the same cycle.
// Assumes tick_i is a one-cycle pulse and NB >= 2.
module sac_counter
    import sac_pkg::*;
#(
    parameter int NB = SAC_NBYTES,
    parameter int DW = SAC_DW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             ctrl_we_i,
    input  logic [NB-1:0]    wwin_we_i,
    input  logic [DW-1:0]    wdata_i,
    output logic             run_o,
    output logic [NB*DW-1:0] count_o
);
    localparam int CW = NB * DW;

    logic [NB-1:1][DW-1:0] shadow_q;
    logic [CW-1:0]         count_q;
    logic                  run_q;

    // Run control bit.
    always_ff @(posedge clk) begin
        if (!rst_n)          run_q <= 1'b0;
        else if (ctrl_we_i)  run_q <= wdata_i[RUN_BIT];
    end

    // Holding registers for the upper bytes of a new time.
    always_ff @(posedge clk) begin
        if (!rst_n) shadow_q <= '0;
        else begin
            for (int i = 1; i < NB; i++)
                if (wwin_we_i[i]) shadow_q[i] <= wdata_i;
        end
    end

    // Count: commit has priority, otherwise step on a running tick.
    always_ff @(posedge clk) begin
        if (!rst_n)                count_q <= '0;
        else if (wwin_we_i[0])     count_q <= {shadow_q, wdata_i};
        else if (run_q && tick_i)  count_q <= count_q + 1'b1;
    end

    assign run_o   = run_q;
    assign count_o = count_q;

    // R3: stopped and not loaded means the count holds.
    a_r3_halt: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_q && !wwin_we_i[0]) |=> $stable(count_q));
    // R3/R4: a running tick steps by one, modulo the count width.
    a_r4_step: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && tick_i && !wwin_we_i[0]) |=> (count_q == $past(count_q) + 1'b1));
    // R5/R6: a lowest-byte write loads held bytes plus data, tick ignored.
    a_r6_commit: assert property (@(posedge clk) disable iff (!rst_n)
        wwin_we_i[0] |=> (count_q == {$past(shadow_q), $past(wdata_i)}));
endmodule

// File: rtl/sac_alarm.sv
// Alarm value, enable and latched pending flag. A match sets the flag
// while enabled; only a write with the clear bit set lowers it, and the
// clear wins if it coincides with a match.
module sac_alarm
    import sac_pkg::*;
#(
    parameter int NB = SAC_NBYTES,
    parameter int DW = SAC_DW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             actl_we_i,
    input  logic             aclr_we_i,
    input  logic [NB-1:0]    aval_we_i,
    input  logic [DW-1:0]    wdata_i,
    input  logic [NB*DW-1:0] count_i,
    output logic             aen_o,
    output logic [NB*DW-1:0] aval_o,
    output logic             irq_o
);
    logic [NB-1:0][DW-1:0] aval_q;
    logic                  aen_q;
    logic                  pend_q;
    logic                  clr;
    logic                  hit;

    assign clr = aclr_we_i && wdata_i[ACLR_BIT];
    assign hit = aen_q && (count_i == aval_q);

    // Alarm enable bit.
    always_ff @(posedge clk) begin
        if (!rst_n)         aen_q <= 1'b0;
        else if (actl_we_i) aen_q <= wdata_i[AEN_BIT];
    end

    // Alarm compare value, byte-writable.
    always_ff @(posedge clk) begin
        if (!rst_n) aval_q <= '0;
        else begin
            for (int i = 0; i < NB; i++)
                if (aval_we_i[i]) aval_q[i] <= wdata_i;
        end
    end

    // Pending flag: clear first, then set on an enabled match.
    always_ff @(posedge clk) begin
        if (!rst_n)   pend_q <= 1'b0;
        else if (clr) pend_q <= 1'b0;
        else if (hit) pend_q <= 1'b1;
    end

    assign aen_o  = aen_q;
    assign aval_o = aval_q;
    assign irq_o  = pend_q;

    // R8: a rise needs an enabled match in the previous cycle.
    a_r8_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> ($past(aen_q) && ($past(count_i) == $past(aval_q))));
    // R8: disabled and idle stays idle.
    a_r8_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!aen_q && !irq_o) |=> !irq_o);
    // R9: the level holds until a clear.
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !clr) |=> irq_o);
    // R9: a clear drops the level at the next edge.
    a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !irq_o);
endmodule

// File: rtl/sec_alarm_counter.sv
// Top level: seconds counter with alarm behind an 8-bit register port.
// Assumes a one-cycle tick pulse per second from outside the block.
module sec_alarm_counter
    import sac_pkg::*;
#(
    parameter int NB     = SAC_NBYTES,
    parameter int DW     = SAC_DW,
    parameter int ADDR_W = SAC_AW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic              reg_we_i,
    input  logic [DW-1:0]     reg_wdata_i,
    output logic [DW-1:0]     reg_rdata_o,
    output logic              alarm_irq_o
);
    localparam int CW = NB * DW;

    sac_wstb_t     wstb;
    logic [NB-1:0] wwin_we;
    logic [NB-1:0] aval_we;
    logic          run;
    logic          aen;
    logic [CW-1:0] count;
    logic [CW-1:0] aval;

    sac_regdec #(.NB(NB), .DW(DW), .ADDR_W(ADDR_W)) u_dec (
        .addr_i    (reg_addr_i),
        .we_i      (reg_we_i),
        .run_i     (run),
        .aen_i     (aen),
        .count_i   (count),
        .aval_i    (aval),
        .wstb_o    (wstb),
        .wwin_we_o (wwin_we),
        .aval_we_o (aval_we),
        .rdata_o   (reg_rdata_o)
    );

    sac_counter #(.NB(NB), .DW(DW)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick_i),
        .ctrl_we_i (wstb.ctrl),
        .wwin_we_i (wwin_we),
        .wdata_i   (reg_wdata_i),
        .run_o     (run),
        .count_o   (count)
    );

    sac_alarm #(.NB(NB), .DW(DW)) u_alm (
        .clk       (clk),
        .rst_n     (rst_n),
        .actl_we_i (wstb.actl),
        .aclr_we_i (wstb.aclr),
        .aval_we_i (aval_we),
        .wdata_i   (reg_wdata_i),
        .count_i   (count),
        .aen_o     (aen),
        .aval_o    (aval),
        .irq_o     (alarm_irq_o)
    );
endmodule

// File: tb/sec_alarm_counter_tb_top.sv
// Self-checking bench: drives the register port and tick, computes
// every expected value arithmetically from the requirements.
module sec_alarm_counter_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic [3:0] addr = '0;
    logic       we = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       irq;
    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #5 clk = ~clk;

    sec_alarm_counter dut_i (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .reg_addr_i(addr),
        .reg_we_i(we), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
        .alarm_irq_o(irq)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(logic [3:0] a, logic [7:0] d, bit tk = 0);
        @(negedge clk);
        addr = a; wdata = d; we = 1'b1; tick = tk;
        @(negedge clk);
        we = 1'b0; tick = 1'b0;
    endtask

    task automatic rd(logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic rd32(logic [3:0] base, output logic [31:0] v);
        logic [7:0] b;
        for (int i = 0; i < 4; i++) begin
            rd(base + 4'(i), b);
            v[i*8 +: 8] = b;
        end
    endtask

    task automatic pulse(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
    endtask

    task automatic set_time(logic [31:0] v);
        wr(4'h2, 8'h00);
        wr(4'h3, v[15:8]);
        wr(4'h4, v[23:16]);
        wr(4'h5, v[31:24]);
        wr(4'h2, v[7:0]);
    endtask

    task automatic set_alarm(logic [31:0] v);
        for (int i = 0; i < 4; i++) wr(4'hA + 4'(i), v[i*8 +: 8]);
    endtask

    initial begin : wdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [7:0]  b, b0;
        logic [31:0] v, exp;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state of every address and the interrupt
        for (int a = 0; a < 16; a++) begin
            rd(4'(a), b);
            chk("R1 reset read", 32'(b), 32'h0);
        end
        chk("R1 irq after reset", 32'(irq), 32'h0);

        // R5: held bytes do not touch the count until the lowest-byte write
        wr(4'h2, 8'h00);
        wr(4'h3, 8'h56); wr(4'h4, 8'h34); wr(4'h5, 8'h12);
        rd32(4'h6, v);
        chk("R5 held bytes no effect", v, 32'h0);
        rd(4'h3, b);
        chk("R5 write window reads zero", 32'(b), 32'h0);
        wr(4'h2, 8'h78);
        rd32(4'h6, v);
        chk("R5 R2 commit and byte order", v, 32'h12345678);

        // R3: stopped counter ignores ticks
        pulse(5);
        rd32(4'h6, v);
        chk("R3 stopped", v, 32'h12345678);
        wr(4'h0, 8'hFF);
        rd(4'h0, b);
        chk("R3 run bit readback", 32'(b), 32'h80);

        // R3: running sweep across byte carries
        exp = 32'h12345678;
        for (int i = 0; i < 300; i++) begin
            pulse(1);
            exp = exp + 1;
            rd32(4'h6, v);
            chk("R3 run step", v, exp);
        end

        // R10: carry out of the lowest byte is visible at once
        set_time(32'h000001FF);
        rd(4'h6, b0);
        pulse(1);
        rd(4'h6, b);
        chk("R10 low byte smaller after carry", 32'(b < b0), 32'h1);
        rd(4'h7, b);
        chk("R10 next byte incremented", 32'(b), 32'h02);

        // R4: wrap from all ones to zero
        set_time(32'hFFFFFFFE);
        pulse(2);
        rd32(4'h6, v);
        chk("R4 wrap", v, 32'h0);

        // R6: commit with a simultaneous tick
        wr(4'h3, 8'hBB); wr(4'h4, 8'hCC); wr(4'h5, 8'hDD);
        wr(4'h2, 8'hAA, 1);
        rd32(4'h6, v);
        chk("R6 commit beats tick", v, 32'hDDCCBBAA);

        // R7: alarm value readback over several patterns
        for (int k = 0; k < 8; k++) begin
            exp = 32'h01020304 * 32'(k + 1) ^ 32'hA5A5_0000;
            set_alarm(exp);
            rd32(4'hA, v);
            chk("R7 alarm readback", v, exp);
        end

        // R8: disabled alarm stays quiet through a match
        wr(4'h0, 8'h00);
        set_time(32'd100);
        set_alarm(32'd103);
        wr(4'h0, 8'h80);
        pulse(5);
        @(negedge clk);
        chk("R8 disabled no irq", 32'(irq), 32'h0);

        // R8/R9: sweep of match distances with exact firing tick
        for (int k = 1; k <= 8; k++) begin
            wr(4'h1, 8'h00);
            wr(4'hE, 8'h01);
            set_time(32'd1000);
            set_alarm(32'd1000 + 32'(k));
            wr(4'h1, 8'h80);
            rd(4'h1, b);
            chk("R8 enable readback", 32'(b), 32'h80);
            pulse(k - 1);
            @(negedge clk);
            chk("R8 no irq before match", 32'(irq), 32'h0);
            pulse(1);
            @(negedge clk);
            chk("R8 irq after match", 32'(irq), 32'h1);
            pulse(2);
            chk("R9 irq holds", 32'(irq), 32'h1);
            wr(4'hE, 8'hFE);
            @(negedge clk);
            chk("R9 clear bit zero no effect", 32'(irq), 32'h1);
            wr(4'hE, 8'h01);
            @(negedge clk);
            chk("R9 cleared", 32'(irq), 32'h0);
            rd(4'hE, b);
            chk("R9 clear reads zero", 32'(b), 32'h0);
        end

        // R2: unused address ignores writes and reads zero
        wr(4'h0, 8'h00);
        set_time(32'h0BADF00D);
        wr(4'hF, 8'hFF);
        rd(4'hF, b);
        chk("R2 unused reads zero", 32'(b), 32'h0);
        rd32(4'h6, v);
        chk("R2 unused write no effect on count", v, 32'h0BADF00D);
        rd(4'h0, b);
        chk("R2 unused write no effect on control", 32'(b), 32'h0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule